// File: doc/BRIEF.md
# Power-Bus Command Port

This block lets a host processor start single transactions on a serial power-management bus through a small set of 32-bit registers. The host loads up to eight outgoing data bytes, the target slave number, the byte count, and a 16-bit register address split into a high byte and a low byte. A write to the opcode register then launches the transaction. The block presents the whole request to a downstream bus engine over a valid/ready handshake and waits for that engine's single-cycle response.

When the response arrives, the block records a four-flag outcome: done, failure, denied and dropped. A successful response also stores the returned bytes in eight read-back registers. A response timer guarantees that the port always frees itself. If the engine never answers, the transaction is closed as a failure. A launch attempted while a transaction is still in flight is not queued. It is discarded and reported through the dropped flag when the current transaction completes. The opcode goes to the engine unchanged; the port does not interpret it.

Top module: `pbus_cmd_port`

## Requirements
- R1: After reset, every register reads zero, the status reads zero and `reqValid` is low.
- R2: The register file holds the following fields. Word 0x04 holds the slave number in bits [3:0] and the byte count minus one in bits [6:4]; bit 7 reads zero. Word 0x08 holds the high address byte and word 0x0C the low address byte. Word 0x00 reads back the opcode in bits [5:1]. Outgoing byte n is at 0x18+4n and returned byte n at 0x38+4n, using bits [7:0] only. Status is at 0x14. Any other offset, including an unaligned one, reads zero, and `regRdata` is zero whenever `regRe` is low.
- R3: A write to 0x00 while idle has these effects on the next cycle. The status is cleared to zero. `reqValid` rises with `reqOpcode` taken from bits [5:1] of the written word, and `reqSlave` and `reqCountM1` taken from word 0x04. `reqAddr` carries the high byte from 0x08 in bits [15:8] and the low byte from 0x0C in bits [7:0], and outgoing byte n appears on `reqData[8n+7:8n]`.
- R4: `reqValid` stays high and all request fields stay stable until the cycle in which `reqReady` is high; `reqValid` is low on the following cycle.
- R5: On the cycle after a `rspValid` pulse that answers an accepted request, the status is updated. Bit 0 (done) is set. Bit 1 (failure) is set for `rspCode` 1 or 3, and bit 2 (denied) is set for `rspCode` 2. `rspCode` 0 is success and sets neither bit.
- R6: A successful response (`rspCode` 0) copies `rspData[8n+7:8n]` into returned byte n; any other outcome leaves the returned bytes unchanged.
- R7: If no response arrives within `TIMEOUT_CYCLES` clock edges after the launch edge, the status becomes 0x3 (done and failure) on that edge, `reqValid` falls and the port accepts a new launch.
- R8: A write to 0x00 while a transaction is outstanding does not start a request or clear the status. It sets status bit 3 (dropped) together with done when the outstanding transaction completes.
- R9: While a transaction is outstanding, writes to 0x04, 0x08, 0x0C and the outgoing byte words are ignored.
- R10: A `rspValid` pulse while no request is outstanding changes neither the status nor the returned bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational, zero when not reading |
| reqValid | output | 1 | Request to the bus engine is pending |
| reqReady | input | 1 | Bus engine accepts the request |
| reqOpcode | output | 5 | Transaction opcode |
| reqSlave | output | 4 | Target slave number |
| reqAddr | output | 16 | Register address, high byte in [15:8] |
| reqCountM1 | output | 3 | Byte count minus one |
| reqData | output | 64 | Outgoing bytes, byte n in [8n+7:8n] |
| rspValid | input | 1 | One-cycle response pulse |
| rspCode | input | 2 | Outcome: 0 ok, 1 failure, 2 denied, 3 treated as failure |
| rspData | input | 64 | Returned bytes, byte n in [8n+7:8n] |

## Verification
The sequencer state shows at the ports through two signals. If it stays in the request phase, `reqValid` remains high after the handshake cycle. If it loses its place, the status differs from the value the host expects one cycle after the response or the timer expiry. A lost dropped marker, a timer off by one edge, or a return-data capture on a failed outcome each shows up in the first status or returned-byte read after the transaction closes. These are checked on exact cycles against a bench model, under random opcodes, lengths, outcomes and handshake delays, with directed timeout and collision cases added.

// File: rtl/pbus_cmd_pkg.sv
package pbus_cmd_pkg;

  // Word offsets of the register file
  localparam logic [7:0] OFS_OP   = 8'h00;
  localparam logic [7:0] OFS_SLV  = 8'h04;
  localparam logic [7:0] OFS_HI   = 8'h08;
  localparam logic [7:0] OFS_LO   = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_WD   = 8'h18;
  localparam logic [7:0] OFS_RD   = 8'h38;

  // Status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_DENY = 2;
  localparam int ST_DROP = 3;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_FAIL = 2'd1,
    RSP_DENY = 2'd2,
    RSP_RSVD = 2'd3
  } rspCode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seqState_e;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic       launch;
    logic       busy;
    logic       setStatus;
    logic [3:0] statusVal;
    logic       captureRd;
  } ctrlStrobe_t;

endpackage

// File: rtl/pbus_cmd_ctrl.sv
module pbus_cmd_ctrl
  import pbus_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic        reqReady,
  input  logic        rspValid,
  input  logic [1:0]  rspCode,
  output logic        reqValid,
  output ctrlStrobe_t strb
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  seqState_e        state;
  logic [TMR_W-1:0] timer;
  logic             dropPend;

  logic launchWr, busy, rspHit, expire, finish, dropNow;
  logic [3:0] statusNext;

  assign launchWr = regWe && (regAddr == OFS_OP);
  assign busy     = (state != S_IDLE);
  assign rspHit   = (state == S_WAIT) && rspValid;
  assign expire   = busy && !rspHit && (timer == TMR_LAST);
  assign finish   = rspHit || expire;
  assign dropNow  = dropPend || (launchWr && busy);

  always_comb begin
    statusNext = 4'b0000;
    statusNext[ST_DONE] = 1'b1;
    if (expire) begin
      statusNext[ST_FAIL] = 1'b1;
    end else begin
      unique case (rspCode_e'(rspCode))
        RSP_OK:   ;
        RSP_DENY: statusNext[ST_DENY] = 1'b1;
        default:  statusNext[ST_FAIL] = 1'b1;
      endcase
    end
    statusNext[ST_DROP] = dropNow;
  end

  always_comb begin
    strb.launch    = launchWr && !busy;
    strb.busy      = busy;
    strb.setStatus = finish;
    strb.statusVal = statusNext;
    strb.captureRd = rspHit && (rspCode == RSP_OK);
  end

  assign reqValid = (state == S_REQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      timer    <= '0;
      dropPend <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          timer <= '0;
          if (launchWr) state <= S_REQ;
        end
        S_REQ: begin
          timer <= timer + 1'b1;
          if (expire)        state <= S_IDLE;
          else if (reqReady) state <= S_WAIT;
        end
        S_WAIT: begin
          timer <= timer + 1'b1;
          if (finish) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (finish)                dropPend <= 1'b0;
      else if (launchWr && busy) dropPend <= 1'b1;
    end
  end

  // R4: request held until accepted
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady && !expire |=> reqValid);

  // R4: request withdrawn after the handshake
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid);

  // R5: every completion reports done
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStatus |-> strb.statusVal[ST_DONE]);

  // R7: timer never passes its limit while busy
  p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (timer < TMR_W'(TIMEOUT_CYCLES)));

  // R7: port released after a completion
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStatus |=> !reqValid);

endmodule

// File: rtl/pbus_cmd_dpath.sv
module pbus_cmd_dpath
  import pbus_cmd_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int CNT_W    = $clog2(NUM_BYTES),
  localparam int DATA_W   = 8 * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] rspData,
  output logic [4:0]        reqOpcode,
  output logic [3:0]        reqSlave,
  output logic [15:0]       reqAddr,
  output logic [CNT_W-1:0]  reqCountM1,
  output logic [DATA_W-1:0] reqData
);

  logic [4:0]       opcode;
  logic [3:0]       slaveId;
  logic [CNT_W-1:0] countM1;
  logic [7:0]       addrHi, addrLo;
  logic [3:0]       statusReg;
  logic [7:0]       wdArr [NUM_BYTES];
  logic [7:0]       rdArr [NUM_BYTES];
  logic             cfgWe;
  logic             unusedWdata;

  assign cfgWe       = regWe && !strb.busy;
  assign unusedWdata = ^{regWdata[31:8], regWdata[7-CNT_W+4 -: 1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode    <= '0;
      slaveId   <= '0;
      countM1   <= '0;
      addrHi    <= '0;
      addrLo    <= '0;
      statusReg <= '0;
    end else begin
      if (strb.launch) begin
        opcode    <= regWdata[5:1];
        statusReg <= '0;
      end else if (strb.setStatus) begin
        statusReg <= strb.statusVal;
      end
      if (cfgWe && regAddr == OFS_SLV) begin
        slaveId <= regWdata[3:0];
        countM1 <= regWdata[4 +: CNT_W];
      end
      if (cfgWe && regAddr == OFS_HI) addrHi <= regWdata[7:0];
      if (cfgWe && regAddr == OFS_LO) addrLo <= regWdata[7:0];
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam logic [7:0] W_OFS = OFS_WD + 8'(4 * b);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wdArr[b] <= '0;
        rdArr[b] <= '0;
      end else begin
        if (cfgWe && regAddr == W_OFS) wdArr[b] <= regWdata[7:0];
        if (strb.captureRd)            rdArr[b] <= rspData[8*b +: 8];
      end
    end
    assign reqData[8*b +: 8] = wdArr[b];

    // R6: returned bytes move only on a successful response
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      !strb.captureRd |=> $stable(rdArr[b]));
  end

  always_comb begin
    regRdata = '0;
    if (regRe) begin
      unique case (regAddr)
        OFS_OP:   regRdata = {26'b0, opcode, 1'b0};
        OFS_SLV:  regRdata = 32'({countM1, slaveId});
        OFS_HI:   regRdata = {24'b0, addrHi};
        OFS_LO:   regRdata = {24'b0, addrLo};
        OFS_STAT: regRdata = {28'b0, statusReg};
        default: begin
          for (int b = 0; b < NUM_BYTES; b++) begin
            if (regAddr == OFS_WD + 8'(4 * b)) regRdata = {24'b0, wdArr[b]};
            if (regAddr == OFS_RD + 8'(4 * b)) regRdata = {24'b0, rdArr[b]};
          end
        end
      endcase
    end
  end

  assign reqOpcode  = opcode;
  assign reqSlave   = slaveId;
  assign reqAddr    = {addrHi, addrLo};
  assign reqCountM1 = countM1;

  // R3: launch clears the status
  p_clear_on_launch_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> statusReg == 4'b0);

  // R4 / R9: request fields frozen while outstanding
  p_fields_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(opcode) && $stable(slaveId) && $stable(countM1)
                  && $stable(addrHi) && $stable(addrLo));

  // R9: configuration write while busy has no effect
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy && regWe && regAddr == OFS_SLV |=> $stable(slaveId));

  // R5: status changes only at launch or completion
  p_status_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.launch && !strb.setStatus |=> $stable(statusReg));

endmodule

// File: rtl/pbus_cmd_port.sv
module pbus_cmd_port
  import pbus_cmd_pkg::*;
#(
  parameter int NUM_BYTES      = 8,
  parameter int TIMEOUT_CYCLES = 16,
  localparam int CNT_W  = $clog2(NUM_BYTES),
  localparam int DATA_W = 8 * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [4:0]        reqOpcode,
  output logic [3:0]        reqSlave,
  output logic [15:0]       reqAddr,
  output logic [CNT_W-1:0]  reqCountM1,
  output logic [DATA_W-1:0] reqData,
  input  logic              rspValid,
  input  logic [1:0]        rspCode,
  input  logic [DATA_W-1:0] rspData
);

  ctrlStrobe_t strb;

  pbus_cmd_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspCode  (rspCode),
    .reqValid (reqValid),
    .strb     (strb)
  );

  pbus_cmd_dpath #(.NUM_BYTES(NUM_BYTES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regRe      (regRe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .strb       (strb),
    .rspData    (rspData),
    .reqOpcode  (reqOpcode),
    .reqSlave   (reqSlave),
    .reqAddr    (reqAddr),
    .reqCountM1 (reqCountM1),
    .reqData    (reqData)
  );

endmodule

// File: tb/pbus_cmd_port_bench.sv
module pbus_cmd_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid, reqReady = 1'b0;
  logic [4:0]  reqOpcode;
  logic [3:0]  reqSlave;
  logic [15:0] reqAddr;
  logic [2:0]  reqCountM1;
  logic [63:0] reqData;
  logic        rspValid = 1'b0;
  logic [1:0]  rspCode = '0;
  logic [63:0] rspData = '0;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] expRd = '0;
  logic [3:0]  expStat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_cmd_port #(.NUM_BYTES(8), .TIMEOUT_CYCLES(TMO)) u_pbus_cmd_port (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqReady(reqReady), .reqOpcode(reqOpcode), .reqSlave(reqSlave),
    .reqAddr(reqAddr), .reqCountM1(reqCountM1), .reqData(reqData),
    .rspValid(rspValid), .rspCode(rspCode), .rspData(rspData)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = '0; regWdata = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regRe = 1'b1; regAddr = a;
    #1;
    d = regRdata;
    regRe = 1'b0; regAddr = '0;
  endtask

  function automatic logic [3:0] expStatus(input logic [1:0] code, input bit drop);
    logic [3:0] s;
    s = 4'b0001;
    if (code == 2'd1 || code == 2'd3) s[1] = 1'b1;
    if (code == 2'd2) s[2] = 1'b1;
    s[3] = drop;
    return s;
  endfunction

  function automatic logic [4:0] pickOp(input int i);
    case (i % 14)
      0: return 5'd0;   1: return 5'd1;   2: return 5'd2;   3: return 5'd3;
      4: return 5'd4;   5: return 5'd5;   6: return 5'd6;   7: return 5'd7;
      8: return 5'd8;   9: return 5'd9;   10: return 5'd13; 11: return 5'd14;
      12: return 5'd15; default: return 5'd16;
    endcase
  endfunction

  task automatic checkRdBytes(input string tag);
    logic [31:0] v;
    for (int n = 0; n < 8; n++) begin
      regRead(8'h38 + 8'(4*n), v);
      chk(tag, v, {56'b0, expRd[8*n +: 8]});
    end
  endtask

  task automatic loadCmd(input logic [4:0] op, input logic [3:0] sid, input logic [7:0] hi,
                         input logic [7:0] lo, input logic [2:0] cm1, input logic [63:0] wd);
    logic [31:0] junk;
    for (int n = 0; n < 8; n++) regWrite(8'h18 + 8'(4*n), {24'hABCDEF, wd[8*n +: 8]});
    regWrite(8'h04, {24'h0, 1'b0, cm1, sid});
    regWrite(8'h08, {24'h0, hi});
    regWrite(8'h0C, {24'h0, lo});
    junk = $urandom;
    regWrite(8'h00, {junk[31:6], op, junk[0]});
  endtask

  task automatic runTxn(input logic [4:0] op, input logic [3:0] sid, input logic [7:0] hi,
                        input logic [7:0] lo, input logic [2:0] cm1, input logic [63:0] wd,
                        input logic [1:0] code, input int rdyDly, input int rspDly,
                        input logic [63:0] rdat, input bit collide);
    logic [31:0] v;
    loadCmd(op, sid, hi, lo, cm1, wd);
    chk("R3 reqValid after launch", reqValid, 1);
    chk("R3 opcode", reqOpcode, op);
    chk("R3 slave", reqSlave, sid);
    chk("R3 address", reqAddr, {hi, lo});
    chk("R3 count", reqCountM1, cm1);
    chk("R3 data", reqData, wd);
    regRead(8'h14, v);
    chk("R3 status cleared", v, 0);
    for (int k = 0; k < rdyDly; k++) begin
      @(negedge clk);
      chk("R4 held", {reqValid, reqOpcode, reqAddr}, {1'b1, op, hi, lo});
    end
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
    chk("R4 withdrawn", reqValid, 0);
    if (collide) begin
      regWrite(8'h00, 32'h2);
      chk("R8 no new request", reqValid, 0);
      regWrite(8'h04, 32'h5A);
      regRead(8'h04, v);
      chk("R9 slave reg locked", v, {25'b0, cm1, sid});
      regWrite(8'h18, 32'h77);
      regRead(8'h18, v);
      chk("R9 data reg locked", v, {24'b0, wd[7:0]});
    end
    for (int k = 0; k < rspDly; k++) @(negedge clk);
    rspValid = 1'b1; rspCode = code; rspData = rdat;
    @(negedge clk);
    rspValid = 1'b0; rspData = '0; rspCode = '0;
    expStat = expStatus(code, collide);
    if (code == 2'd0) expRd = rdat;
    regRead(8'h14, v);
    chk(collide ? "R8 dropped status" : "R5 status", v, {28'b0, expStat});
    checkRdBytes("R6 returned bytes");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1C3A5));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reqValid", reqValid, 0);
    regRead(8'h14, v); chk("R1 status", v, 0);
    regRead(8'h04, v); chk("R1 slave reg", v, 0);
    regRead(8'h00, v); chk("R1 opcode reg", v, 0);
    checkRdBytes("R1 returned bytes");

    // R2 register map
    regWrite(8'h04, 32'hFFFF_FFFF);
    regRead(8'h04, v); chk("R2 slave/count field", v, 32'h7F);
    regWrite(8'h08, 32'h1234_56A5);
    regRead(8'h08, v); chk("R2 high byte", v, 32'hA5);
    regWrite(8'h2C, 32'hFFFF_FF3C);
    regRead(8'h2C, v); chk("R2 data byte 5", v, 32'h3C);
    regRead(8'h10, v); chk("R2 undefined 0x10", v, 0);
    regRead(8'h58, v); chk("R2 undefined 0x58", v, 0);
    regRead(8'h19, v); chk("R2 unaligned", v, 0);
    regRe = 1'b0; regAddr = 8'h2C; #1;
    chk("R2 no read strobe", regRdata, 0);

    // Directed transactions
    runTxn(5'd15, 4'hF, 8'h01, 8'hFF, 3'd7, 64'h0102030405060708, 2'd0, 0, 0,
           64'hF0E1D2C3B4A59687, 1'b0);
    runTxn(5'd14, 4'h0, 8'h40, 8'h00, 3'd0, 64'h00000000000000EE, 2'd2, 3, 2,
           64'h1111111111111111, 1'b0);
    runTxn(5'd16, 4'h3, 8'h22, 8'h33, 3'd1, 64'hCAFE, 2'd3, 1, 1,
           64'h2222222222222222, 1'b0);
    runTxn(5'd1, 4'h7, 8'h05, 8'h06, 3'd3, 64'h0, 2'd0, 2, 1,
           64'h00000000DEADBEEF, 1'b1);

    // R10 response while idle
    @(negedge clk);
    rspValid = 1'b1; rspCode = 2'd1; rspData = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    rspValid = 1'b0; rspData = '0; rspCode = '0;
    regRead(8'h14, v); chk("R10 status kept", v, {28'b0, expStat});
    checkRdBytes("R10 returned bytes kept");

    // R7 timeout with no handshake
    loadCmd(5'd8, 4'h2, 8'h10, 8'h20, 3'd2, 64'h55);
    repeat (TMO - 1) @(negedge clk);
    chk("R7 still pending", reqValid, 1);
    regRead(8'h14, v); chk("R7 status before expiry", v, 0);
    @(negedge clk);
    chk("R7 request withdrawn", reqValid, 0);
    regRead(8'h14, v); chk("R7 timeout status", v, 32'h3);

    // R7 timeout after handshake
    loadCmd(5'd9, 4'h4, 8'h11, 8'h21, 3'd0, 64'h66);
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
    repeat (TMO - 2) @(negedge clk);
    regRead(8'h14, v); chk("R7 waiting status", v, 0);
    @(negedge clk);
    regRead(8'h14, v); chk("R7 timeout in wait", v, 32'h3);
    checkRdBytes("R7 returned bytes kept");

    // Constrained random transactions
    for (int i = 0; i < 40; i++) begin
      logic [63:0] wd, rd;
      logic [31:0] r;
      wd = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      r  = $urandom;
      runTxn(pickOp(int'(r[7:4])), r[11:8], r[19:12], r[27:20], r[30:28], wd,
             2'($urandom_range(0, 3)), int'($urandom_range(0, 4)),
             int'($urandom_range(0, 4)), rd, (r[3:0] == 4'd0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule